// File: doc/BRIEF.md
# Pitch-Linear Copy Request Generator

This block is the front end of a copy engine. Software drives it through a flat space of 32-bit method words. Each method write stores its argument at a word index. A write to the launch word starts a transfer.

The block then turns the stored source address, destination address, pitches, line length and line count into a stream of per-line requests. Each request carries a source address, a destination address and a byte count. The transfer is either a single contiguous run or a rectangle walked line by line, with separate strides on the read side and the write side. A data mover downstream accepts the requests over a valid/ready handshake. The block itself moves no data.

Launches that ask for anything beyond pitch-to-pitch copying end in a one-cycle error pulse and issue no requests. The unsupported features are tiled layouts, semaphores, interrupts, component remapping, and any transfer type other than non-pipelined.

Top module: `cpy2d_frontend`

## Requirements
- R1: A method write with index below the window size stores its argument. The parameter words live at these indices:
  - 0x100: source upper word.
  - 0x101: source lower word.
  - 0x102: destination upper word.
  - 0x103: destination lower word.
  - 0x104: read pitch.
  - 0x105: write pitch.
  - 0x106: line length in bytes.
  - 0x107: line count.

  A write to index 0xC0 starts a transfer using the word written in that same cycle.
- R2: Each 40-bit address is {upper[7:0], lower[31:0]}. Bits 31:8 of the upper word have no effect.
- R3: Launch word fields are: [1:0] transfer type, [2] flush, [4:3] semaphore type, [6:5] interrupt type, [7] source layout, [8] destination layout (1 means pitch), [9] multi-line, [10] remap. When multi-line is 0, exactly one request is issued: {source, destination, line length}.
- R4: When multi-line is 1, line-count requests are issued. Request n carries source + n*read pitch and destination + n*write pitch, both taken modulo 2^40, and the line length.
- R5: A launch with both layout bits 0 pulses `err` for one cycle and issues no request.
- R6: A launch also pulses `err` and issues no request if any of these holds: the transfer type is not 2, the semaphore type is nonzero, the interrupt type is nonzero, remap is 1, or either layout bit is 0. The flush bit has no effect.
- R7: A write with index at or above 0x800 raises `mw_reject` in the same cycle. It stores nothing and never launches, including when its low 11 bits alias a valid index.
- R8: While `req_valid` is high and `req_ready` is low, the request fields and `req_valid` hold unchanged.
- R9: `busy` rises in the cycle after an accepted launch and stays high until the last request is accepted. `done` then pulses for exactly one cycle.
- R10: A multi-line launch with a line count of 0 pulses `done` one cycle after the launch, without `busy` and without any request.
- R11: Parameter writes during a transfer update the stored words but leave the running transfer unchanged. A launch write while `busy` is high starts nothing.
- R12: After reset, `busy`, `req_valid`, `done` and `err` are low and all stored parameter words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mw_valid | input | 1 | Method write strobe |
| mw_index | input | IDX_W (16) | Method word index |
| mw_data | input | 32 | Method argument |
| mw_reject | output | 1 | Write index is outside the window |
| req_valid | output | 1 | Line request present |
| req_ready | input | 1 | Downstream accepts the request |
| req_src | output | 32+HI_BITS (40) | Line source address |
| req_dst | output | 32+HI_BITS (40) | Line destination address |
| req_len | output | 32 | Line length in bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle unsupported-launch pulse |

## Verification
The bench builds the block with its defaults: a 16-bit index, a 0x800-word window and 8 upper address bits. The 16-bit index lets it send indices such as 0x0900 and 0x08C0, whose low bits alias real registers, to show that rejection is decided on the full index. The 8-bit upper field puts a 40-bit wrap within reach of a three-line walk started just below 2^40.

// File: rtl/cpy_pkg.sv
package cpy_pkg;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned IDX_LAUNCH = 'h0C0;
   localparam int unsigned WIN_BASE   = 'h100;
   localparam int unsigned WIN_WORDS  = 8;

   // slot numbers inside the parameter window
   localparam int unsigned SLOT_SRC_HI = 0;
   localparam int unsigned SLOT_SRC_LO = 1;
   localparam int unsigned SLOT_DST_HI = 2;
   localparam int unsigned SLOT_DST_LO = 3;
   localparam int unsigned SLOT_PIN    = 4;
   localparam int unsigned SLOT_POUT   = 5;
   localparam int unsigned SLOT_LEN    = 6;
   localparam int unsigned SLOT_CNT    = 7;

   localparam logic [1:0] XFER_NON_PIPELINED = 2'd2;

   // launch word bits [10:0], most significant field first
   typedef struct packed {
      logic       remap;
      logic       multi_line;
      logic       dst_pitch;
      logic       src_pitch;
      logic [1:0] intr;
      logic [1:0] sem;
      logic       flush;
      logic [1:0] xfer;
   } launch_t;
endpackage

// File: rtl/cpy_regfile.sv
module cpy_regfile #(
   parameter int unsigned IDX_W   = 16,
   parameter int unsigned SPACE   = 'h800,
   parameter int unsigned HI_BITS = 8,
   localparam int unsigned ADDR_W = cpy_pkg::WORD_W + HI_BITS,
   localparam int unsigned NREG   = cpy_pkg::WIN_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [31:0]       wr_data,
   output logic              reject,
   output logic              launch_stb,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] dst_addr,
   output logic [31:0]       pitch_in,
   output logic [31:0]       pitch_out,
   output logic [31:0]       line_len,
   output logic [31:0]       line_cnt
);
   import cpy_pkg::*;

   localparam logic [IDX_W:0]   SPACE_L  = (IDX_W+1)'(SPACE);
   localparam logic [IDX_W-1:0] LAUNCH_L = IDX_W'(IDX_LAUNCH);

   logic [NREG-1:0][31:0] shadow_q;
   logic                  in_range;

   assign in_range   = ({1'b0, wr_idx} < SPACE_L);
   assign reject     = wr_en && !in_range;
   assign launch_stb = wr_en && in_range && (wr_idx == LAUNCH_L);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (wr_en && in_range) begin
         for (int k = 0; k < NREG; k++) begin
            if (wr_idx == IDX_W'(WIN_BASE + k)) shadow_q[k] <= wr_data;
         end
      end
   end

   assign src_addr  = {shadow_q[SLOT_SRC_HI][HI_BITS-1:0], shadow_q[SLOT_SRC_LO]};
   assign dst_addr  = {shadow_q[SLOT_DST_HI][HI_BITS-1:0], shadow_q[SLOT_DST_LO]};
   assign pitch_in  = shadow_q[SLOT_PIN];
   assign pitch_out = shadow_q[SLOT_POUT];
   assign line_len  = shadow_q[SLOT_LEN];
   assign line_cnt  = shadow_q[SLOT_CNT];

   AST_OOR_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !in_range) |=> $stable(shadow_q)); // R7
endmodule

// File: rtl/cpy_launch_check.sv
module cpy_launch_check (
   input  logic [31:0] word,
   output logic        ok,
   output logic        multi
);
   import cpy_pkg::*;

   launch_t f;

   assign f     = launch_t'(word[$bits(launch_t)-1:0]);
   assign multi = f.multi_line;
   assign ok    = (f.xfer == XFER_NON_PIPELINED) && (f.sem == 2'd0) &&
                  (f.intr == 2'd0) && !f.remap && f.src_pitch && f.dst_pitch;
endmodule

// File: rtl/cpy_line_walker.sv
module cpy_line_walker #(
   parameter int unsigned ADDR_W  = 40,
   parameter int unsigned PITCH_W = 32,
   parameter int unsigned LEN_W   = 32,
   parameter int unsigned CNT_W   = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               start_ok,
   input  logic               start_multi,
   input  logic [ADDR_W-1:0]  src_in,
   input  logic [ADDR_W-1:0]  dst_in,
   input  logic [PITCH_W-1:0] pin_in,
   input  logic [PITCH_W-1:0] pout_in,
   input  logic [LEN_W-1:0]   len_in,
   input  logic [CNT_W-1:0]   cnt_in,
   input  logic               req_ready,
   output logic               req_valid,
   output logic [ADDR_W-1:0]  req_src,
   output logic [ADDR_W-1:0]  req_dst,
   output logic [LEN_W-1:0]   req_len,
   output logic               busy,
   output logic               done,
   output logic               err
);
   logic [PITCH_W-1:0] pin_q, pout_q;
   logic [ADDR_W-1:0]  pin_ext, pout_ext;
   logic [CNT_W-1:0]   rem_q, first_n;
   logic               accept;

   if (ADDR_W > PITCH_W) begin : g_pad
      assign pin_ext  = {{(ADDR_W-PITCH_W){1'b0}}, pin_q};
      assign pout_ext = {{(ADDR_W-PITCH_W){1'b0}}, pout_q};
   end else begin : g_trunc
      assign pin_ext  = pin_q[ADDR_W-1:0];
      assign pout_ext = pout_q[ADDR_W-1:0];
   end

   assign first_n = start_multi ? cnt_in : CNT_W'(1);
   assign accept  = req_valid && req_ready;
   assign busy    = req_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_src   <= '0;
         req_dst   <= '0;
         req_len   <= '0;
         pin_q     <= '0;
         pout_q    <= '0;
         rem_q     <= '0;
         done      <= 1'b0;
         err       <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         if (start && !req_valid) begin
            if (!start_ok) begin
               err <= 1'b1;
            end else if (first_n == '0) begin
               done <= 1'b1;
            end else begin
               req_valid <= 1'b1;
               req_src   <= src_in;
               req_dst   <= dst_in;
               req_len   <= len_in;
               pin_q     <= pin_in;
               pout_q    <= pout_in;
               rem_q     <= first_n;
            end
         end else if (accept) begin
            if (rem_q == CNT_W'(1)) begin
               req_valid <= 1'b0;
               done      <= 1'b1;
            end else begin
               req_src <= req_src + pin_ext;
               req_dst <= req_dst + pout_ext;
               rem_q   <= rem_q - CNT_W'(1);
            end
         end
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_src) &&
                                     $stable(req_dst) && $stable(req_len))); // R8
   AST_BUSY_UNTIL_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !req_ready) |=> busy); // R9
   AST_LAUNCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy && !req_ready) |=> ($stable(req_src) && !err)); // R11
   AST_ERR_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !done); // R6
endmodule

// File: rtl/cpy2d_frontend.sv
module cpy2d_frontend #(
   parameter int unsigned IDX_W   = 16,
   parameter int unsigned SPACE   = 'h800,
   parameter int unsigned HI_BITS = 8,
   localparam int unsigned ADDR_W = 32 + HI_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mw_valid,
   input  logic [IDX_W-1:0]  mw_index,
   input  logic [31:0]       mw_data,
   output logic              mw_reject,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_src,
   output logic [ADDR_W-1:0] req_dst,
   output logic [31:0]       req_len,
   output logic              busy,
   output logic              done,
   output logic              err
);
   if (HI_BITS < 1 || HI_BITS > 32) begin : g_bad_hi
      $error("HI_BITS must be within 1..32");
   end
   if (SPACE <= 'h107 || SPACE > (2 ** IDX_W)) begin : g_bad_space
      $error("SPACE must cover the parameter window and fit the index width");
   end

   logic              launch_stb, launch_ok, launch_multi;
   logic [ADDR_W-1:0] src_a, dst_a;
   logic [31:0]       pin, pout, len, cnt;

   cpy_regfile #(.IDX_W(IDX_W), .SPACE(SPACE), .HI_BITS(HI_BITS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(mw_valid), .wr_idx(mw_index),
      .wr_data(mw_data), .reject(mw_reject), .launch_stb(launch_stb),
      .src_addr(src_a), .dst_addr(dst_a), .pitch_in(pin), .pitch_out(pout),
      .line_len(len), .line_cnt(cnt));

   cpy_launch_check u_chk (
      .word(mw_data), .ok(launch_ok), .multi(launch_multi));

   cpy_line_walker #(.ADDR_W(ADDR_W), .PITCH_W(32), .LEN_W(32), .CNT_W(32)) u_walk (
      .clk(clk), .rst_n(rst_n), .start(launch_stb), .start_ok(launch_ok),
      .start_multi(launch_multi), .src_in(src_a), .dst_in(dst_a),
      .pin_in(pin), .pout_in(pout), .len_in(len), .cnt_in(cnt),
      .req_ready(req_ready), .req_valid(req_valid), .req_src(req_src),
      .req_dst(req_dst), .req_len(req_len), .busy(busy), .done(done), .err(err));

   AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !req_valid); // R5
endmodule

// File: tb/tb_cpy2d_frontend.sv
module tb_cpy2d_frontend;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mw_valid = 1'b0;
   logic [15:0] mw_index = '0;
   logic [31:0] mw_data = '0;
   logic        mw_reject;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [39:0] req_src, req_dst;
   logic [31:0] req_len;
   logic        busy, done, err;

   int n_chk = 0;
   int n_err = 0;
   bit last_rej;

   always #10 clk = ~clk; // 20 time units: 50 MHz at 1 ns

   cpy2d_frontend dut (
      .clk(clk), .rst_n(rst_n), .mw_valid(mw_valid), .mw_index(mw_index),
      .mw_data(mw_data), .mw_reject(mw_reject), .req_valid(req_valid),
      .req_ready(req_ready), .req_src(req_src), .req_dst(req_dst),
      .req_len(req_len), .busy(busy), .done(done), .err(err));

   localparam int NV = 10;
   // launch, src hi/lo, dst hi/lo, pitch in/out, len, count, ready mode, expect err, expect requests
   localparam logic [31:0] V_LAUNCH [NV] = '{32'h182, 32'h382, 32'h386, 32'h382, 32'h202,
                                             32'h302, 32'h38A, 32'h782, 32'h381, 32'h3A2};
   localparam logic [31:0] V_SHI [NV] = '{32'h12, 32'h01, 32'hABCDEFFF, 32'h0, 32'h0,
                                          32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
   localparam logic [31:0] V_SLO [NV] = '{32'h10000000, 32'h0, 32'hFFFFFFF0, 32'h500, 32'h1,
                                          32'h2, 32'h3, 32'h4, 32'h5, 32'h6};
   localparam logic [31:0] V_DHI [NV] = '{32'h0, 32'h02, 32'h0, 32'h0, 32'h0,
                                          32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
   localparam logic [31:0] V_DLO [NV] = '{32'h20000000, 32'h80, 32'h100, 32'h600, 32'h9,
                                          32'h9, 32'h9, 32'h9, 32'h9, 32'h9};
   localparam logic [31:0] V_PIN [NV] = '{32'h0, 32'h40, 32'h20, 32'h8, 32'h4,
                                          32'h4, 32'h4, 32'h4, 32'h4, 32'h4};
   localparam logic [31:0] V_POUT [NV] = '{32'h0, 32'h80, 32'h10, 32'h8, 32'h4,
                                           32'h4, 32'h4, 32'h4, 32'h4, 32'h4};
   localparam logic [31:0] V_LEN [NV] = '{32'h100, 32'h30, 32'h8, 32'h8, 32'h4,
                                          32'h4, 32'h4, 32'h4, 32'h4, 32'h4};
   localparam logic [31:0] V_CNT [NV] = '{32'd5, 32'd4, 32'd3, 32'd0, 32'd2,
                                          32'd2, 32'd2, 32'd2, 32'd2, 32'd2};
   localparam int V_MODE [NV] = '{0, 1, 0, 0, 0, 0, 0, 0, 0, 0};
   localparam bit V_ERR  [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 1, 1};
   localparam int V_NREQ [NV] = '{1, 4, 3, 0, 0, 0, 0, 0, 0, 0};

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] idx, input logic [31:0] d);
      @(negedge clk);
      mw_valid = 1'b1; mw_index = idx; mw_data = d;
      #1 last_rej = mw_reject;
      @(negedge clk);
      mw_valid = 1'b0;
   endtask

   task automatic prog(input logic [31:0] sh, sl, dh, dl, pi, po, ln, cn);
      wr(16'h100, sh); wr(16'h101, sl); wr(16'h102, dh); wr(16'h103, dl);
      wr(16'h104, pi); wr(16'h105, po); wr(16'h106, ln); wr(16'h107, cn);
   endtask

   // entered at the negedge that follows the launch edge
   task automatic collect(input int mode, input logic [39:0] s0, d0,
                          input logic [31:0] pi, po, ln, input int nexp,
                          input bit experr, input string req);
      int got = 0;
      int cyc = 0;
      bit seen_done = 0, seen_err = 0, hold = 0;
      logic [39:0] hs = '0, hd = '0, es, ed;
      logic [31:0] hl = '0;
      while (!seen_done && !seen_err && cyc < 400) begin
         if (err) seen_err = 1;
         if (done) seen_done = 1;
         if (hold) begin
            check(req_valid && req_src == hs && req_dst == hd && req_len == hl,
                  "R8", "request held under stall", {24'b0, req_src}, {24'b0, hs});
            hold = 0;
         end
         if (req_valid) begin
            check(busy, "R9", "busy while request pending", 64'(busy), 64'd1);
            req_ready = (mode == 0) ? 1'b1 : cyc[0];
            if (req_ready) begin
               es = 40'((64'(s0) + 64'(got) * 64'(pi)) & 64'hFF_FFFF_FFFF);
               ed = 40'((64'(d0) + 64'(got) * 64'(po)) & 64'hFF_FFFF_FFFF);
               check(req_src == es, req, "line source", {24'b0, req_src}, {24'b0, es});
               check(req_dst == ed, req, "line destination", {24'b0, req_dst}, {24'b0, ed});
               check(req_len == ln, req, "line length", 64'(req_len), 64'(ln));
               got++;
            end else begin
               hold = 1; hs = req_src; hd = req_dst; hl = req_len;
            end
         end else begin
            req_ready = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      req_ready = 1'b0;
      check(seen_err == experr, experr ? "R6" : req, "error pulse", 64'(seen_err), 64'(experr));
      check(got == nexp, req, "request count", 64'(got), 64'(nexp));
      if (!experr) check(seen_done, "R9", "done pulse", 64'(seen_done), 64'd1);
      check(!busy && !req_valid, "R9", "idle after end", 64'(busy), 64'd0);
      check(!done && !err, "R9", "pulses last one cycle", 64'({done, err}), 64'd0);
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: idle outputs and zeroed parameter words
      check(!busy && !req_valid && !done && !err, "R12", "reset outputs",
            64'({busy, req_valid, done, err}), 64'd0);
      wr(16'h0C0, 32'h182);
      collect(0, 40'h0, 40'h0, 32'h0, 32'h0, 32'h0, 1, 0, "R12");

      // table walk: R1 R2 R3 R4 R5 R6 R10
      for (int v = 0; v < NV; v++) begin
         prog(V_SHI[v], V_SLO[v], V_DHI[v], V_DLO[v], V_PIN[v], V_POUT[v], V_LEN[v], V_CNT[v]);
         wr(16'h0C0, V_LAUNCH[v]);
         collect(V_MODE[v], {V_SHI[v][7:0], V_SLO[v]}, {V_DHI[v][7:0], V_DLO[v]},
                 V_PIN[v], V_POUT[v], V_LEN[v], V_NREQ[v], V_ERR[v],
                 V_CNT[v] == 0 && V_LAUNCH[v][9] ? "R10" :
                 (V_NREQ[v] > 1 ? "R4" : (V_ERR[v] ? "R5" : "R3")));
      end

      // R7: out-of-window writes rejected, no aliasing, no launch
      prog(32'h0, 32'h1234, 32'h0, 32'h5678, 32'h0, 32'h0, 32'h10, 32'h1);
      check(!last_rej, "R7", "in-window write not rejected", 64'(last_rej), 64'd0);
      wr(16'h0901, 32'hDEAD);
      check(last_rej, "R7", "reject flag on 0x0901", 64'(last_rej), 64'd1);
      wr(16'h08C0, 32'h182);
      check(last_rej, "R7", "reject flag on 0x08C0", 64'(last_rej), 64'd1);
      check(!busy && !err && !done && !req_valid, "R7", "aliased launch ignored",
            64'({busy, err, done, req_valid}), 64'd0);
      wr(16'h0C0, 32'h182);
      collect(0, 40'h1234, 40'h5678, 32'h0, 32'h0, 32'h10, 1, 0, "R7");

      // R11: shadow writes and launch during a stalled transfer
      prog(32'h0, 32'h4000, 32'h0, 32'h8000, 32'h10, 32'h20, 32'h4, 32'd3);
      wr(16'h0C0, 32'h382);
      check(busy, "R9", "busy after launch", 64'(busy), 64'd1);
      wr(16'h104, 32'h999);
      wr(16'h100, 32'h55);
      wr(16'h0C0, 32'h182);
      check(!err, "R11", "launch while busy raises no error", 64'(err), 64'd0);
      collect(0, 40'h4000, 40'h8000, 32'h10, 32'h20, 32'h4, 3, 0, "R11");
      wr(16'h0C0, 32'h382);
      collect(0, {8'h55, 32'h4000}, 40'h8000, 32'h999, 32'h20, 32'h4, 3, 0, "R11");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule